// File: doc/BRIEF.md
# Renamed Out-of-Order ALU Core

This block is a compact execution core for register-to-register arithmetic. It takes one decoded instruction per cycle (an operation code, a destination register and two source registers) and places it in a small circular reorder buffer. A rename table records, for each architectural register, either its committed value or the buffer slot that will produce its next value. Operands are resolved when the instruction is dispatched. Each one is taken from the committed value, from a result already sitting in the buffer, or from the result being produced in that same cycle. If none of these is available, the operand is left waiting on the producer's slot number.

One shared ALU runs the oldest buffered instruction whose operands are both present. It broadcasts the result together with the producer's slot number, and every waiting consumer picks it up in the same cycle. Results leave the buffer strictly from the head and in program order. Each one updates the committed register state and appears on a retire port. Software-visible behaviour is therefore that of a plain in-order machine. After reset, architectural register i holds the value i+1.

Top module: `ooo_alu_core`

## Requirements
- R1: After reset the buffer is empty, `disp_ready` is 1, `retire_valid` is 0, and architectural register i holds i+1 (modulo 2^DW).
- R2: `disp_op` encodes the operation on the two source values a (src1) and b (src2): 2'b00 gives a+b, 2'b01 gives a-b, 2'b10 gives a XOR b and 2'b11 gives a OR b, all modulo 2^DW.
- R3: Instructions retire one per cycle at most and strictly in dispatch order. Each retirement shows the instruction's destination on `retire_reg` and its result on `retire_data`, and the sequence matches an in-order execution of the same stream.
- R4: A source register whose latest writer has not yet retired receives that writer's result. This holds when the writer completes before, during, or after the consumer's dispatch cycle.
- R5: When two instructions in flight write the same register, later readers receive the younger writer's result. Retiring the older writer does not expose its value to them.
- R6: `disp_ready` is 0 exactly when all ROB_DEPTH buffer slots are occupied. While it is 0, `disp_valid` is ignored and no instruction is accepted.
- R7: At most one instruction executes per cycle, and each executes exactly once. Among the slots whose operands are both present, the one nearest the head is chosen.
- R8: A register whose rename entry is pending names a live buffer slot, and that slot's destination is this register. For every live slot whose destination is pending, the pending tag is that slot or a younger live slot.
- R9: On each result broadcast, every live slot with a missing operand that waits on the broadcasting slot captures the value and marks the operand present in the next cycle's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_op | input | 2 | Operation code (see R2) |
| disp_dst | input | $clog2(NREG) | Destination register |
| disp_src1 | input | $clog2(NREG) | First source register (a) |
| disp_src2 | input | $clog2(NREG) | Second source register (b) |
| disp_ready | output | 1 | A buffer slot is free; an offered instruction is taken this cycle |
| retire_valid | output | 1 | The head instruction retires this cycle |
| retire_reg | output | $clog2(NREG) | Destination of the retiring instruction |
| retire_data | output | DW | Result of the retiring instruction |

## Verification
The bench goes after back-to-back dependency chains, where a consumer is dispatched in the very cycle its producer broadcasts. A design without dispatch-time forwarding would leave that operand waiting forever, and the scoreboard would then see no retirement. It also sends repeated writes to one register followed by a reader. A design that re-validated the rename entry on the older writer's retirement would feed the reader a stale value. Bursts run long enough to fill the buffer, so that a full/empty mix-up or an accepted stalled instruction shows up as a missing, extra or misordered retirement. A long randomized stream with idle gaps is compared against an in-order reference model of the register file.

// File: rtl/ooo_pkg.sv
package ooo_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_XOR = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

endpackage

// File: rtl/ooo_alu.sv
module ooo_alu
  import ooo_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (alu_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_XOR:  y = a ^ b;
      default: y = a | b;
    endcase
  end

endmodule

// File: rtl/ooo_pick.sv
module ooo_pick #(
  parameter int ROB_DEPTH = 4,
  localparam int TW = $clog2(ROB_DEPTH)
) (
  input  logic [ROB_DEPTH-1:0] req,
  input  logic [TW-1:0]        head_idx,
  output logic                 gnt_valid,
  output logic [TW-1:0]        gnt_idx
);

  logic [TW-1:0] idx;

  // scan from youngest to oldest so the slot nearest the head wins
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    idx       = '0;
    for (int k = ROB_DEPTH - 1; k >= 0; k--) begin
      idx = head_idx + TW'(k);
      if (req[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = idx;
      end
    end
  end

endmodule

// File: rtl/ooo_rename.sv
module ooo_rename #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [RW-1:0]             rd1_reg,
  input  logic [RW-1:0]             rd2_reg,
  output logic                      rd1_v,
  output logic [TW-1:0]             rd1_tag,
  output logic [DW-1:0]             rd1_val,
  output logic                      rd2_v,
  output logic [TW-1:0]             rd2_tag,
  output logic [DW-1:0]             rd2_val,
  input  logic                      alloc_en,
  input  logic [RW-1:0]             alloc_reg,
  input  logic [TW-1:0]             alloc_tag,
  input  logic                      commit_en,
  input  logic [RW-1:0]             commit_reg,
  input  logic [TW-1:0]             commit_tag,
  input  logic [DW-1:0]             commit_val,
  output logic [NREG-1:0]           map_v,
  output logic [NREG-1:0][TW-1:0]   map_tag
);

  logic [NREG-1:0]         v_q, v_n;
  logic [NREG-1:0][TW-1:0] t_q, t_n;
  logic [NREG-1:0][DW-1:0] val_q, val_n;

  assign rd1_v   = v_q[rd1_reg];
  assign rd1_tag = t_q[rd1_reg];
  assign rd1_val = val_q[rd1_reg];
  assign rd2_v   = v_q[rd2_reg];
  assign rd2_tag = t_q[rd2_reg];
  assign rd2_val = val_q[rd2_reg];
  assign map_v   = v_q;
  assign map_tag = t_q;

  always_comb begin
    v_n   = v_q;
    t_n   = t_q;
    val_n = val_q;
    if (commit_en) begin
      val_n[commit_reg] = commit_val;
      if (!v_q[commit_reg] && (t_q[commit_reg] == commit_tag))
        v_n[commit_reg] = 1'b1;
    end
    // a new writer overrides any same-cycle commit to its register
    if (alloc_en) begin
      v_n[alloc_reg] = 1'b0;
      t_n[alloc_reg] = alloc_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        v_q[i]   <= 1'b1;
        t_q[i]   <= '0;
        val_q[i] <= DW'(i + 1);
      end
    end else begin
      v_q   <= v_n;
      t_q   <= t_n;
      val_q <= val_n;
    end
  end

endmodule

// File: rtl/ooo_alu_core.sv
module ooo_alu_core
  import ooo_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int DW        = 16,
  parameter int ROB_DEPTH = 4,
  localparam int RW = $clog2(NREG),
  localparam int TW = $clog2(ROB_DEPTH),
  localparam int PW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic [1:0]    disp_op,
  input  logic [RW-1:0] disp_dst,
  input  logic [RW-1:0] disp_src1,
  input  logic [RW-1:0] disp_src2,
  output logic          disp_ready,
  output logic          retire_valid,
  output logic [RW-1:0] retire_reg,
  output logic [DW-1:0] retire_data
);

  // pointers with one wrap bit
  logic [PW-1:0] head_q, tail_q, count;
  logic [TW-1:0] head_idx, tail_idx;

  // reorder buffer slots
  logic [ROB_DEPTH-1:0]           res_v_q, res_v_n;
  logic [ROB_DEPTH-1:0][DW-1:0]   res_q, res_n;
  logic [ROB_DEPTH-1:0]           o1v_q, o1v_n, o2v_q, o2v_n;
  logic [ROB_DEPTH-1:0][DW-1:0]   o1val_q, o1val_n, o2val_q, o2val_n;
  logic [ROB_DEPTH-1:0][TW-1:0]   o1tag_q, o1tag_n, o2tag_q, o2tag_n;
  logic [ROB_DEPTH-1:0][RW-1:0]   dst_q, dst_n;
  logic [ROB_DEPTH-1:0][1:0]      op_q, op_n;

  logic [ROB_DEPTH-1:0] live, req;
  logic                 disp_fire, ret_fire;
  logic                 bc_valid;
  logic [TW-1:0]        bc_tag;
  logic [DW-1:0]        bc_val;

  logic                 r1_v, r2_v;
  logic [TW-1:0]        r1_tag, r2_tag;
  logic [DW-1:0]        r1_val, r2_val;
  logic [NREG-1:0]         map_v;
  logic [NREG-1:0][TW-1:0] map_tag;
  logic [DW+TW:0]       s1, s2;

  assign head_idx = head_q[TW-1:0];
  assign tail_idx = tail_q[TW-1:0];
  assign count    = tail_q - head_q;

  generate
    for (genvar t = 0; t < ROB_DEPTH; t++) begin : g_slot
      logic [TW-1:0] age;
      assign age     = TW'(t) - head_idx;
      assign live[t] = ({1'b0, age} < count);
      assign req[t]  = live[t] && o1v_q[t] && o2v_q[t] && !res_v_q[t];
    end
  endgenerate

  assign disp_ready   = (count != PW'(ROB_DEPTH));
  assign disp_fire    = disp_valid && disp_ready;
  assign ret_fire     = live[head_idx] && res_v_q[head_idx];
  assign retire_valid = ret_fire;
  assign retire_reg   = dst_q[head_idx];
  assign retire_data  = res_q[head_idx];

  ooo_rename #(.NREG(NREG), .DW(DW), .TW(TW)) u_rename (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd1_reg    (disp_src1),
    .rd2_reg    (disp_src2),
    .rd1_v      (r1_v),
    .rd1_tag    (r1_tag),
    .rd1_val    (r1_val),
    .rd2_v      (r2_v),
    .rd2_tag    (r2_tag),
    .rd2_val    (r2_val),
    .alloc_en   (disp_fire),
    .alloc_reg  (disp_dst),
    .alloc_tag  (tail_idx),
    .commit_en  (ret_fire),
    .commit_reg (dst_q[head_idx]),
    .commit_tag (head_idx),
    .commit_val (res_q[head_idx]),
    .map_v      (map_v),
    .map_tag    (map_tag)
  );

  ooo_pick #(.ROB_DEPTH(ROB_DEPTH)) u_pick (
    .req       (req),
    .head_idx  (head_idx),
    .gnt_valid (bc_valid),
    .gnt_idx   (bc_tag)
  );

  ooo_alu #(.DW(DW)) u_alu (
    .op (op_q[bc_tag]),
    .a  (o1val_q[bc_tag]),
    .b  (o2val_q[bc_tag]),
    .y  (bc_val)
  );

  // operand source order: committed value, same-cycle broadcast, buffered result, wait
  function automatic logic [DW+TW:0] resolve(input logic rv, input logic [TW-1:0] rt,
                                             input logic [DW-1:0] rval);
    if (rv)                          return {1'b1, rval, rt};
    else if (bc_valid && bc_tag == rt) return {1'b1, bc_val, rt};
    else if (res_v_q[rt])            return {1'b1, res_q[rt], rt};
    else                             return {1'b0, {DW{1'b0}}, rt};
  endfunction

  assign s1 = resolve(r1_v, r1_tag, r1_val);
  assign s2 = resolve(r2_v, r2_tag, r2_val);

  always_comb begin
    res_v_n = res_v_q;  res_n   = res_q;
    o1v_n   = o1v_q;    o1val_n = o1val_q;  o1tag_n = o1tag_q;
    o2v_n   = o2v_q;    o2val_n = o2val_q;  o2tag_n = o2tag_q;
    dst_n   = dst_q;    op_n    = op_q;
    if (bc_valid) begin
      for (int t = 0; t < ROB_DEPTH; t++) begin
        if (live[t] && !o1v_q[t] && o1tag_q[t] == bc_tag) begin
          o1v_n[t]   = 1'b1;
          o1val_n[t] = bc_val;
        end
        if (live[t] && !o2v_q[t] && o2tag_q[t] == bc_tag) begin
          o2v_n[t]   = 1'b1;
          o2val_n[t] = bc_val;
        end
      end
      res_v_n[bc_tag] = 1'b1;
      res_n[bc_tag]   = bc_val;
    end
    if (disp_fire) begin
      res_v_n[tail_idx] = 1'b0;
      o1v_n[tail_idx]   = s1[DW+TW];
      o1val_n[tail_idx] = s1[DW+TW-1:TW];
      o1tag_n[tail_idx] = s1[TW-1:0];
      o2v_n[tail_idx]   = s2[DW+TW];
      o2val_n[tail_idx] = s2[DW+TW-1:TW];
      o2tag_n[tail_idx] = s2[TW-1:0];
      dst_n[tail_idx]   = disp_dst;
      op_n[tail_idx]    = disp_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;  tail_q  <= '0;
      res_v_q <= '0;  res_q   <= '0;
      o1v_q   <= '0;  o1val_q <= '0;  o1tag_q <= '0;
      o2v_q   <= '0;  o2val_q <= '0;  o2tag_q <= '0;
      dst_q   <= '0;  op_q    <= '0;
    end else begin
      if (ret_fire)  head_q <= head_q + PW'(1);
      if (disp_fire) tail_q <= tail_q + PW'(1);
      res_v_q <= res_v_n;  res_q   <= res_n;
      o1v_q   <= o1v_n;    o1val_q <= o1val_n;  o1tag_q <= o1tag_n;
      o2v_q   <= o2v_n;    o2val_q <= o2val_n;  o2tag_q <= o2tag_n;
      dst_q   <= dst_n;    op_q    <= op_n;
    end
  end

endmodule

// File: rtl/ooo_alu_core_chk.sv
module ooo_alu_core_chk #(
  parameter int NREG      = 8,
  parameter int ROB_DEPTH = 4,
  localparam int RW = $clog2(NREG),
  localparam int TW = $clog2(ROB_DEPTH)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ROB_DEPTH-1:0]           live,
  input logic [TW-1:0]                  head_idx,
  input logic [ROB_DEPTH-1:0]           res_v,
  input logic [ROB_DEPTH-1:0]           o1v,
  input logic [ROB_DEPTH-1:0]           o2v,
  input logic [ROB_DEPTH-1:0][TW-1:0]   o1tag,
  input logic [ROB_DEPTH-1:0][TW-1:0]   o2tag,
  input logic [ROB_DEPTH-1:0][RW-1:0]   dst,
  input logic                           bc_valid,
  input logic [TW-1:0]                  bc_tag,
  input logic [NREG-1:0]                map_v,
  input logic [NREG-1:0][TW-1:0]        map_tag,
  input logic                           retire_valid
);

  logic [TW-1:0] bc_age;
  assign bc_age = bc_tag - head_idx;

  AST_BCAST_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> live[bc_tag] && !res_v[bc_tag] && o1v[bc_tag] && o2v[bc_tag]); // R7

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> head_idx == TW'($past(head_idx) + 1'b1)); // R3

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      AST_MAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !map_v[r] |-> live[map_tag[r]] && dst[map_tag[r]] == RW'(r)); // R8
    end
    for (genvar t = 0; t < ROB_DEPTH; t++) begin : g_ent
      logic [TW-1:0] my_age, map_age;
      assign my_age  = TW'(t) - head_idx;
      assign map_age = map_tag[dst[t]] - head_idx;

      AST_MAP_NOT_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
        live[t] && !map_v[dst[t]] |-> map_age >= my_age); // R8

      AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid && live[t] && o1v[t] && o2v[t] && !res_v[t] |-> bc_age <= my_age); // R7

      AST_WAKE_OP1: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid && live[t] && !o1v[t] && o1tag[t] == bc_tag |=> o1v[t]); // R9

      AST_WAKE_OP2: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid && live[t] && !o2v[t] && o2tag[t] == bc_tag |=> o2v[t]); // R9
    end
  endgenerate

endmodule

bind ooo_alu_core ooo_alu_core_chk #(.NREG(NREG), .ROB_DEPTH(ROB_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .live         (live),
  .head_idx     (head_idx),
  .res_v        (res_v_q),
  .o1v          (o1v_q),
  .o2v          (o2v_q),
  .o1tag        (o1tag_q),
  .o2tag        (o2tag_q),
  .dst          (dst_q),
  .bc_valid     (bc_valid),
  .bc_tag       (bc_tag),
  .map_v        (map_v),
  .map_tag      (map_tag),
  .retire_valid (retire_valid)
);

// File: tb/tb_ooo_alu_core.sv
module tb_ooo_alu_core;

  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 2;
  localparam int RW    = $clog2(NREG);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          disp_valid = 1'b0;
  logic [1:0]    disp_op = '0;
  logic [RW-1:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
  logic          disp_ready, retire_valid;
  logic [RW-1:0] retire_reg;
  logic [DW-1:0] retire_data;

  int tests = 0;
  int fails = 0;
  string cur_req = "R3";
  bit stall_seen = 1'b0;
  logic [DW-1:0] ref_rf [NREG];
  logic [RW+DW-1:0] exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ooo_alu_core #(.NREG(NREG), .DW(DW), .ROB_DEPTH(DEPTH)) dut (
    .clk, .rst_n, .disp_valid, .disp_op, .disp_dst, .disp_src1, .disp_src2,
    .disp_ready, .retire_valid, .retire_reg, .retire_data
  );

  function automatic logic [DW-1:0] ref_alu(input logic [1:0] op, input logic [DW-1:0] a, b);
    case (op)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return a ^ b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: offers one instruction and records its in-order result on acceptance
  task automatic issue(input logic [1:0] op, input int d, input int a, input int b);
    bit done = 1'b0;
    @(negedge clk);
    disp_valid = 1'b1;
    disp_op    = op;
    disp_dst   = RW'(d);
    disp_src1  = RW'(a);
    disp_src2  = RW'(b);
    while (!done) begin
      if (disp_ready) begin
        logic [DW-1:0] r;
        r = ref_alu(op, ref_rf[a], ref_rf[b]);
        ref_rf[d] = r;
        exp_q.push_back({RW'(d), r});
        @(posedge clk);
        done = 1'b1;
      end else begin
        stall_seen = 1'b1;
        @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    disp_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the oldest expected retirement and compares
  always @(negedge clk) begin
    if (rst_n && retire_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected retire reg %0d data %0h, expected none",
                 cur_req, retire_reg, retire_data);
      end else begin
        logic [RW+DW-1:0] e;
        e = exp_q.pop_front();
        if ({retire_reg, retire_data} !== e) begin
          fails++;
          $display("FAIL %s: retire reg %0d data %0h, expected reg %0d data %0h",
                   cur_req, retire_reg, retire_data, e[RW+DW-1:DW], e[DW-1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NREG; i++) ref_rf[i] = DW'(i + 1);
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 disp_ready", {31'b0, disp_ready}, 32'd1);
    check("R1 retire_valid", {31'b0, retire_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", {31'b0, disp_ready}, 32'd1);

    // R1 / R2: each opcode on reset values, spaced out
    cur_req = "R2";
    issue(2'b00, 1, 0, 7);
    idle(3);
    issue(2'b01, 2, 3, 5);
    idle(3);
    issue(2'b10, 3, 6, 4);
    idle(3);
    issue(2'b11, 4, 1, 2);
    idle(4);
    check("R2 drained", exp_q.size(), 0);

    // R4: back-to-back dependency chain
    cur_req = "R4";
    issue(2'b00, 5, 1, 2);
    issue(2'b10, 6, 5, 3);
    issue(2'b01, 7, 6, 5);
    issue(2'b00, 5, 7, 7);
    idle(6);
    check("R4 drained", exp_q.size(), 0);

    // R5: repeated writes to one register, then readers
    cur_req = "R5";
    issue(2'b00, 2, 3, 4);
    issue(2'b11, 2, 5, 6);
    issue(2'b00, 0, 2, 2);
    issue(2'b01, 2, 0, 1);
    issue(2'b10, 3, 2, 0);
    idle(6);
    check("R5 drained", exp_q.size(), 0);

    // R6: long burst fills the buffer
    cur_req = "R6";
    stall_seen = 1'b0;
    for (int k = 0; k < 12; k++) issue(2'(k), k % NREG, (k + 3) % NREG, (k + 5) % NREG);
    idle(6);
    check("R6 stall observed", {31'b0, stall_seen}, 32'd1);
    check("R6 no extra accepts", exp_q.size(), 0);

    // R3 / R7 / R9: randomized stream with idle gaps
    cur_req = "R3";
    for (int k = 0; k < 60; k++) begin
      issue(2'($urandom_range(0, 3)), $urandom_range(0, NREG - 1),
            $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 2));
    end
    idle(10);
    check("R3 all retired", exp_q.size(), 0);
    check("R6 ready when empty", {31'b0, disp_ready}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule